// File: doc/BRIEF.md
# Sticky Event Registers with Peek and Clear-on-Read Aliases

This block holds two 8-bit sticky event registers for a four-port power controller. The first register records per-port start-up problems: a class overcurrent and a failed start-up on each port. The second register records supply problems:

- overvoltage and undervoltage on the positive rail and on the negative rail;
- undervoltage lockout on each rail;
- loss of the oscillator signal;
- recovery from a thermal or lockout reset.

Hardware raises a bit with a one-cycle pulse. The bit stays at 1 until software clears it.

Software reads each register through one of two bus addresses. The peek address returns the value and leaves it untouched. The clearing address returns the same value and empties the register in the same clock edge.

A level interrupt is the OR of every held event, with one exception. The oscillator-loss bit counts toward the interrupt only while at least one of four AC-disconnect enable inputs is high.

Top module: `evt_reg_pair`

## Requirements
- R1: After reset both registers read 00h and `irq` is low.
- R2: Start-up register layout: bits [7:4] are the class-overcurrent flags `cls_ovc[3:0]` (port 4 in bit 7, port 1 in bit 4). Bits [3:0] are the start-up failure flags `start_fail[3:0]` (port 4 in bit 3, port 1 in bit 0).
- R3: Supply register layout, from bit 6 down to bit 0: `vdd_ov`, `vdd_uv`, `vee_uvlo`, `vee_ov`, `vee_uv`, `osc_fail`, `vdd_uvlo`.
- R4: Supply bit 7 is set by a pulse on `tsd_recover` or on `uvlo_recover`.
- R5: A set bit stays set, whatever pulses follow, until a clearing read of its register or a reset.
- R6: A read with `rd_en` high at address 08h (start-up) or 0Ah (supply) puts the register value on `rd_data` after the next clock edge. `rd_data` holds that value until the next read. The register itself does not change.
- R7: A read at 09h (start-up) or 0Bh (supply) returns the value the register held before the clear. It then leaves that register at 00h. The other register is not touched.
- R8: An event pulse that arrives in the same cycle as a clearing read of its register leaves its bit set afterwards. The returned data does not include that new bit.
- R9: `irq` is high while any held bit other than supply bit 1 is set. Supply bit 1 also drives `irq`, but only while `acd_en` is nonzero. `irq` falls once the bits that drive it are cleared.
- R10: A read at any other address returns 00h and changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data |
| cls_ovc | input | 4 | Class-overcurrent pulses, one per port |
| start_fail | input | 4 | Start-up failure pulses, one per port |
| vdd_ov | input | 1 | Positive rail overvoltage pulse |
| vdd_uv | input | 1 | Positive rail undervoltage pulse |
| vee_uvlo | input | 1 | Negative rail lockout pulse |
| vee_ov | input | 1 | Negative rail overvoltage pulse |
| vee_uv | input | 1 | Negative rail undervoltage pulse |
| osc_fail | input | 1 | Oscillator amplitude loss pulse |
| vdd_uvlo | input | 1 | Positive rail lockout pulse |
| tsd_recover | input | 1 | Return from thermal shutdown |
| uvlo_recover | input | 1 | Return from lockout reset |
| acd_en | input | 4 | AC-disconnect enables gating the oscillator interrupt |
| irq | output | 1 | Level interrupt |

## Verification
An event pulse and a clearing read can fall in the same cycle and aim at the same bit. The bench provokes this with a pulse on `vdd_uv` on the same edge as a read of 0Bh, while the register already holds a different bit. It judges the result two ways: the read must return only the old content, and a following peek must show the new bit alone. The second pair that can coincide is a peek and a clear issued back to back. The bench checks that the peek returns the full value and that the clear leaves the other register intact.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned PORTS  = 4;
  localparam int unsigned NREGS  = 2;
  localparam int unsigned OSC_BIT = 1;

  localparam logic [ADDR_W-1:0] A_START_PEEK = 8'h08;
  localparam logic [ADDR_W-1:0] A_START_CLR  = 8'h09;
  localparam logic [ADDR_W-1:0] A_SUP_PEEK   = 8'h0A;
  localparam logic [ADDR_W-1:0] A_SUP_CLR    = 8'h0B;

  // next value of a sticky bank: new events win over a clear
  function automatic logic [DATA_W-1:0] sticky_next(
    input logic [DATA_W-1:0] q,
    input logic [DATA_W-1:0] set,
    input logic              clr
  );
    return set | (clr ? '0 : q);
  endfunction

  // read multiplexer: both aliases of a register return the same data
  function automatic logic [DATA_W-1:0] read_pick(
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] start_q,
    input logic [DATA_W-1:0] sup_q
  );
    if (addr == A_START_PEEK || addr == A_START_CLR) return start_q;
    if (addr == A_SUP_PEEK || addr == A_SUP_CLR) return sup_q;
    return '0;
  endfunction

  // interrupt source mask for the supply register
  function automatic logic [DATA_W-1:0] sup_irq_mask(input logic osc_allowed);
    logic [DATA_W-1:0] m;
    m = '1;
    m[OSC_BIT] = osc_allowed;
    return m;
  endfunction
endpackage

// File: rtl/evt_sticky_bank.sv
module evt_sticky_bank #(
  parameter int unsigned W = evt_pkg::DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= evt_pkg::sticky_next(q_o, set_i, clr_i);
  end
endmodule

// File: rtl/evt_read_port.sv
module evt_read_port #(
  parameter int unsigned AW = evt_pkg::ADDR_W,
  parameter int unsigned DW = evt_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] start_q,
  input  logic [DW-1:0] sup_q,
  output logic [DW-1:0] rd_data,
  output logic          clr_start,
  output logic          clr_sup
);
  assign clr_start = rd_en && (rd_addr == evt_pkg::A_START_CLR);
  assign clr_sup   = rd_en && (rd_addr == evt_pkg::A_SUP_CLR);

  // data captured from the pre-clear register value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= evt_pkg::read_pick(rd_addr, start_q, sup_q);
  end
endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen #(
  parameter int unsigned DW   = evt_pkg::DATA_W,
  parameter int unsigned ACDW = evt_pkg::PORTS
) (
  input  logic [DW-1:0]   start_q,
  input  logic [DW-1:0]   sup_q,
  input  logic [ACDW-1:0] acd_en,
  output logic            irq
);
  logic osc_allowed;
  assign osc_allowed = |acd_en;
  assign irq = (|start_q) | (|(sup_q & evt_pkg::sup_irq_mask(osc_allowed)));
endmodule

// File: rtl/evt_reg_pair.sv
module evt_reg_pair #(
  parameter int unsigned PORTS = evt_pkg::PORTS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic [evt_pkg::ADDR_W-1:0]  rd_addr,
  output logic [evt_pkg::DATA_W-1:0]  rd_data,
  input  logic [PORTS-1:0]            cls_ovc,
  input  logic [PORTS-1:0]            start_fail,
  input  logic                        vdd_ov,
  input  logic                        vdd_uv,
  input  logic                        vee_uvlo,
  input  logic                        vee_ov,
  input  logic                        vee_uv,
  input  logic                        osc_fail,
  input  logic                        vdd_uvlo,
  input  logic                        tsd_recover,
  input  logic                        uvlo_recover,
  input  logic [PORTS-1:0]            acd_en,
  output logic                        irq
);
  localparam int unsigned DW = evt_pkg::DATA_W;
  localparam int unsigned NR = evt_pkg::NREGS;

  // named internal events, visible to the checker
  logic [DW-1:0] start_set, sup_set, start_q, sup_q;
  logic          clr_start, clr_sup;
  logic [DW-1:0] bank_set [NR];
  logic [DW-1:0] bank_q   [NR];
  logic [NR-1:0] bank_clr;

  assign start_set = {cls_ovc, start_fail};
  assign sup_set   = {tsd_recover | uvlo_recover, vdd_ov, vdd_uv, vee_uvlo,
                      vee_ov, vee_uv, osc_fail, vdd_uvlo};

  assign bank_set[0] = start_set;
  assign bank_set[1] = sup_set;
  assign bank_clr    = {clr_sup, clr_start};

  for (genvar g = 0; g < NR; g++) begin : g_bank
    evt_sticky_bank #(.W(DW)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (bank_set[g]),
      .clr_i (bank_clr[g]),
      .q_o   (bank_q[g])
    );
  end

  assign start_q = bank_q[0];
  assign sup_q   = bank_q[1];

  evt_read_port u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .start_q   (start_q),
    .sup_q     (sup_q),
    .rd_data   (rd_data),
    .clr_start (clr_start),
    .clr_sup   (clr_sup)
  );

  evt_irq_gen #(.ACDW(PORTS)) u_irq (
    .start_q (start_q),
    .sup_q   (sup_q),
    .acd_en  (acd_en),
    .irq     (irq)
  );
endmodule

// File: rtl/evt_reg_pair_chk.sv
module evt_reg_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic [7:0] rd_addr,
  input logic [7:0] rd_data,
  input logic [7:0] start_q,
  input logic [7:0] sup_q,
  input logic [7:0] start_set,
  input logic [7:0] sup_set,
  input logic       tsd_recover,
  input logic       uvlo_recover,
  input logic [3:0] acd_en,
  input logic       irq
);
  import evt_pkg::*;

  AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_START_PEEK && start_set == 8'h00) |=> start_q == $past(start_q)); // R6

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_START_CLR) |=> (start_q & ~$past(start_set)) == 8'h00); // R7

  AST_CLR_RETURNS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_SUP_CLR) |=> rd_data == $past(sup_q)); // R7

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_addr == A_SUP_CLR) |=> (sup_q & $past(sup_q)) == $past(sup_q)); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(sup_set) & ~sup_q) == 8'h00); // R8

  AST_TSD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd_recover || uvlo_recover) |=> sup_q[7]); // R4

  AST_OSC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_q == 8'h02 && start_q == 8'h00 && acd_en == 4'h0) |-> !irq); // R9

  AST_IRQ_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q != 8'h00) |-> irq); // R9
endmodule

bind evt_reg_pair evt_reg_pair_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_en        (rd_en),
  .rd_addr      (rd_addr),
  .rd_data      (rd_data),
  .start_q      (start_q),
  .sup_q        (sup_q),
  .start_set    (start_set),
  .sup_set      (sup_set),
  .tsd_recover  (tsd_recover),
  .uvlo_recover (uvlo_recover),
  .acd_en       (acd_en),
  .irq          (irq)
);

// File: tb/test_evt_reg_pair.sv
module test_evt_reg_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic [3:0] cls_ovc = '0, start_fail = '0, acd_en = '0;
  logic [6:0] sup = '0;
  logic       tsd_recover = 1'b0, uvlo_recover = 1'b0;
  logic       irq;
  int         n_chk = 0, n_fail = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  evt_reg_pair i_evt_reg_pair (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cls_ovc(cls_ovc), .start_fail(start_fail),
    .vdd_ov(sup[6]), .vdd_uv(sup[5]), .vee_uvlo(sup[4]), .vee_ov(sup[3]),
    .vee_uv(sup[2]), .osc_fail(sup[1]), .vdd_uvlo(sup[0]),
    .tsd_recover(tsd_recover), .uvlo_recover(uvlo_recover),
    .acd_en(acd_en), .irq(irq)
  );

  typedef struct packed {
    logic [3:0] ovc;
    logic [3:0] fail;
    logic [6:0] sup;
    logic       trec;
    logic       urec;
    logic [3:0] acd;
    logic       sel;   // 0 start-up register, 1 supply register
    logic [7:0] exp;
    logic       irq;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{4'h8, 4'h0, 7'h00, 1'b0, 1'b0, 4'h0, 1'b0, 8'h80, 1'b1},
    '{4'h0, 4'h1, 7'h00, 1'b0, 1'b0, 4'h0, 1'b0, 8'h01, 1'b1},
    '{4'h5, 4'hA, 7'h00, 1'b0, 1'b0, 4'h0, 1'b0, 8'h5A, 1'b1},
    '{4'h0, 4'h0, 7'h40, 1'b0, 1'b0, 4'h0, 1'b1, 8'h40, 1'b1},
    '{4'h0, 4'h0, 7'h02, 1'b0, 1'b0, 4'h0, 1'b1, 8'h02, 1'b0},
    '{4'h0, 4'h0, 7'h02, 1'b0, 1'b0, 4'h4, 1'b1, 8'h02, 1'b1},
    '{4'h0, 4'h0, 7'h00, 1'b1, 1'b0, 4'h0, 1'b1, 8'h80, 1'b1},
    '{4'h0, 4'h0, 7'h00, 1'b0, 1'b1, 4'h0, 1'b1, 8'h80, 1'b1},
    '{4'h0, 4'h0, 7'h29, 1'b0, 1'b0, 4'h0, 1'b1, 8'h29, 1'b1},
    '{4'h0, 4'h0, 7'h14, 1'b0, 1'b0, 4'h0, 1'b1, 8'h14, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", {7'b0, irq}, 8'h00);
    rd(8'h08, d); check("R1 start", d, 8'h00);
    rd(8'h0A, d); check("R1 supply", d, 8'h00);

    // table of single-register vectors: R2 R3 R4 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cls_ovc = VEC[i].ovc; start_fail = VEC[i].fail; sup = VEC[i].sup;
      tsd_recover = VEC[i].trec; uvlo_recover = VEC[i].urec; acd_en = VEC[i].acd;
      @(negedge clk);
      cls_ovc = '0; start_fail = '0; sup = '0; tsd_recover = 1'b0; uvlo_recover = 1'b0;
      check(VEC[i].sel ? "R3/R4/R9 irq" : "R2/R9 irq", {7'b0, irq}, {7'b0, VEC[i].irq});
      rd(VEC[i].sel ? 8'h0A : 8'h08, d);
      check(VEC[i].sel ? "R3 R4 R6 peek" : "R2 R6 peek", d, VEC[i].exp);
      rd(VEC[i].sel ? 8'h0B : 8'h09, d);
      check("R7 clear returns value", d, VEC[i].exp);
      rd(VEC[i].sel ? 8'h0A : 8'h08, d);
      check("R7 after clear", d, 8'h00);
      check("R9 irq falls", {7'b0, irq}, 8'h00);
      acd_en = '0;
    end

    // R5 sticky across idle cycles and repeated peeks
    @(negedge clk); start_fail = 4'h4; sup = 7'h40;
    @(negedge clk); start_fail = '0; sup = '0;
    repeat (5) @(negedge clk);
    rd(8'h08, d); check("R5 sticky", d, 8'h04);
    rd(8'h08, d); check("R6 second peek", d, 8'h04);
    // R7 clear only touches its own register
    rd(8'h09, d); check("R7 clr start", d, 8'h04);
    rd(8'h08, d); check("R7 start empty", d, 8'h00);
    rd(8'h0A, d); check("R7 supply kept", d, 8'h40);

    // R8 event coinciding with clearing read
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 8'h0B; sup = 7'h20;
    @(negedge clk);
    rd_en = 1'b0; sup = '0;
    check("R8 pre-clear data", rd_data, 8'h40);
    check("R8 irq held", {7'b0, irq}, 8'h01);
    rd(8'h0A, d); check("R8 new bit kept", d, 8'h20);

    // R10 unmapped addresses
    rd(8'h0C, d); check("R10 addr 0C", d, 8'h00);
    rd(8'h13, d); check("R10 addr 13", d, 8'h00);
    rd(8'h0A, d); check("R10 supply unchanged", d, 8'h20);
    rd(8'h0B, d); check("R7 clear", d, 8'h20);

    // R9 oscillator gating follows acd_en live
    @(negedge clk); sup = 7'h02;
    @(negedge clk); sup = '0;
    check("R9 osc masked", {7'b0, irq}, 8'h00);
    acd_en = 4'h1; #1;
    check("R9 osc enabled", {7'b0, irq}, 8'h01);
    acd_en = 4'h0; #1;
    check("R9 osc masked again", {7'b0, irq}, 8'h00);
    rd(8'h0B, d); check("R7 osc clear", d, 8'h02);

    done = 1'b1;
    finish_run();
  end
endmodule